// File: doc/BRIEF.md
# Line and Field Sync Counter

This block derives line and field timing from a pixel-rate clock. A 12-bit horizontal counter steps through the pixels of a line, and an 11-bit vertical counter steps through the lines of a field. The line length, the length of the final line of a field, the number of lines per field and the widths of the two sync pulses are all programmable. The two horizontal lengths are written in Gray code, with an offset of four pixels.

As master, the block drives active-low line and field sync pulses. An external sync input restarts both counters, and its active level is selectable. As slave, it leaves its sync pins undriven. It then realigns its horizontal counter a fixed seven clocks after each falling edge of the incoming line sync, and its vertical counter after a falling edge of the incoming field sync.

Timing values pass through a shadow stage. A write normally takes effect at the next field start. A write that carries the immediate flag takes effect at once.

Top module: `hv_sync_timer`

## Requirements
- R1: After reset the block is a slave: hd_oe and vd_oe are 0, hd_out and vd_out are 1, hcount_g and vcount are 0. The timing set is 32 pixels per line, 32 on the last line, 6 lines, an HD width of 4 and a VD width of 1.
- R2: A line has g2b(line code)+4 pixels, where g2b takes Gray code to binary (b[11]=g[11], b[i]=b[i+1]^g[i]). hcount_g carries the Gray code (b ^ b>>1) of a binary pixel index that runs from 0 to length-1. Example: code Gray(1556) gives 1560-pixel lines.
- R3: A field has cfg_lines lines, numbered 0 to cfg_lines-1 on vcount. The last of them has g2b(last code)+4 pixels.
- R4: In master mode hd_oe and vd_oe are 1. hd_out is 0 while the pixel index is below the HD width. vd_out is 0 while vcount is below the VD width.
- R5: In master mode, with cfg_sync_pol 0 meaning active low, the clock edge that first samples sync_in at its active level sets both counters to 0. Holding that level does not restart them again.
- R6: In slave mode hd_out and vd_out are 1 and the enables are 0. If the edge that first samples hd_in low after it was high is edge k, then the pixel index is 0 after edge k+7.
- R7: In slave mode, a detected falling edge of vd_in arms a field restart. The next HD realignment after that edge sets vcount to 0 instead of advancing it.
- R8: When an HD realignment falls on the same edge as the natural end of a line, vcount advances exactly once.
- R9: A timing write without cfg_now is held and takes effect at the first field start after it. In master mode a field start is a vertical wrap or a sync restart; in slave mode it is a detected vd_in falling edge.
- R10: A timing write with cfg_now takes effect at its own clock edge. The mode and polarity bits always take effect at the write edge.
- R11: If a deferred write coincides with a field start, the previously held values are applied and the new ones stay pending for the next field start.
- R12: If the pixel index already lies at or beyond the end of a newly shortened line, the line ends at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for all configuration fields |
| cfg_now | input | 1 | Apply timing fields at once instead of at field start |
| cfg_slave | input | 1 | 1 = slave, 0 = master |
| cfg_sync_pol | input | 1 | Active level of sync_in (0 = low) |
| cfg_line_g | input | 12 | Gray code of line pixel count minus 4 |
| cfg_last_g | input | 12 | Gray code of last-line pixel count minus 4 |
| cfg_lines | input | 11 | Lines per field |
| cfg_hd_w | input | 8 | HD low width in pixels |
| cfg_vd_w | input | 8 | VD low width in lines |
| sync_in | input | 1 | External restart pulse (master) |
| hd_in | input | 1 | Line sync input (slave) |
| vd_in | input | 1 | Field sync input (slave) |
| hd_out | output | 1 | Line sync output, active low |
| hd_oe | output | 1 | Drive enable for hd_out |
| vd_out | output | 1 | Field sync output, active low |
| vd_oe | output | 1 | Drive enable for vd_out |
| hcount_g | output | 12 | Pixel index in Gray code |
| vcount | output | 11 | Line index |

## Verification
Two pairs of events can fall in the same cycle, and each could corrupt a count. The first pair is a delayed HD realignment and the natural end of a line; that edge must advance the line index once, not twice. The second pair is a deferred timing write and a field start; the older held set must land while the new one stays pending. The first case is forced directly: hd_in is dropped when the pixel index sits exactly seven short of the line end, and the bench then checks that vcount has moved by one. The second case is forced by writing on the last pixel of the last line. Long random runs also hit both cases, and a cycle model in the bench compares every output on every cycle.

// File: rtl/hv_sync_timer.sv
module hv_sync_timer #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 8,
  parameter int LAT = 7,
  parameter int DEF_PIX = 32,
  parameter int DEF_LAST_PIX = 32,
  parameter int DEF_LINES = 6,
  parameter int DEF_HDW = 4,
  parameter int DEF_VDW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_now,
  input  logic          cfg_slave,
  input  logic          cfg_sync_pol,
  input  logic [HW-1:0] cfg_line_g,
  input  logic [HW-1:0] cfg_last_g,
  input  logic [VW-1:0] cfg_lines,
  input  logic [PW-1:0] cfg_hd_w,
  input  logic [PW-1:0] cfg_vd_w,
  input  logic          sync_in,
  input  logic          hd_in,
  input  logic          vd_in,
  output logic          hd_out,
  output logic          hd_oe,
  output logic          vd_out,
  output logic          vd_oe,
  output logic [HW-1:0] hcount_g,
  output logic [VW-1:0] vcount
);

  localparam logic [HW-1:0] DEF_LINE_B = HW'(DEF_PIX - 4);
  localparam logic [HW-1:0] DEF_LAST_B = HW'(DEF_LAST_PIX - 4);
  localparam logic [HW-1:0] DEF_LINE_G = DEF_LINE_B ^ (DEF_LINE_B >> 1);
  localparam logic [HW-1:0] DEF_LAST_G = DEF_LAST_B ^ (DEF_LAST_B >> 1);

  typedef struct packed {
    logic [HW-1:0] line;
    logic [HW-1:0] last;
    logic [VW-1:0] lines;
    logic [PW-1:0] hdw;
    logic [PW-1:0] vdw;
  } tset_t;

  localparam tset_t DEF_SET = '{line: DEF_LINE_G, last: DEF_LAST_G,
                                lines: VW'(DEF_LINES), hdw: PW'(DEF_HDW),
                                vdw: PW'(DEF_VDW)};

  function automatic logic [HW-1:0] g2b(input logic [HW-1:0] g);
    logic [HW-1:0] b;
    b[HW-1] = g[HW-1];
    for (int i = HW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  tset_t act, stg, wset;
  logic pend;
  logic slave_r, pol_r;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic hd_q, vd_q, sync_q, varm;
  logic [LAT-1:0] dly;

  logic [HW-1:0] a_line;
  logic [PW-1:0] a_hdw;
  logic last_line, line_done, sync_on, sync_hit, hd_fall, vd_fall, realign, field_start;
  logic [HW:0] h_end;

  assign wset = '{line: cfg_line_g, last: cfg_last_g, lines: cfg_lines,
                  hdw: cfg_hd_w, vdw: cfg_vd_w};
  assign a_line = act.line;
  assign a_hdw  = act.hdw;

  assign last_line = ({1'b0, vcnt} + (VW+1)'(1)) >= {1'b0, act.lines};
  assign h_end     = {1'b0, g2b(last_line ? act.last : act.line)} + (HW+1)'(3);
  assign line_done = ({1'b0, hcnt} >= h_end) || (&hcnt);

  assign sync_on  = (sync_in == pol_r);
  assign sync_hit = !slave_r && sync_on && !sync_q;
  assign hd_fall  = slave_r && hd_q && !hd_in;
  assign vd_fall  = slave_r && vd_q && !vd_in;
  assign realign  = slave_r && dly[LAT-1];
  assign field_start = slave_r ? vd_fall : (sync_hit || (line_done && last_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (sync_hit) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (realign || line_done) begin
      hcnt <= '0;
      if ((realign && varm) || last_line) vcnt <= '0;
      else vcnt <= vcnt + VW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q   <= 1'b0;
      vd_q   <= 1'b0;
      sync_q <= 1'b0;
      varm   <= 1'b0;
      dly    <= '0;
    end else begin
      hd_q   <= hd_in;
      vd_q   <= vd_in;
      sync_q <= sync_on;
      dly    <= {dly[LAT-2:0], hd_fall};
      if (vd_fall) varm <= 1'b1;
      else if (realign) varm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= DEF_SET;
      stg     <= DEF_SET;
      pend    <= 1'b0;
      slave_r <= 1'b1;
      pol_r   <= 1'b0;
    end else begin
      if (cfg_we) begin
        slave_r <= cfg_slave;
        pol_r   <= cfg_sync_pol;
      end
      if (cfg_we && cfg_now) begin
        act  <= wset;
        stg  <= wset;
        pend <= 1'b0;
      end else begin
        if (field_start && pend) begin
          act  <= stg;
          pend <= 1'b0;
        end
        if (cfg_we) begin
          stg  <= wset;
          pend <= 1'b1;
        end
      end
    end
  end

  assign hcount_g = hcnt ^ (hcnt >> 1);
  assign vcount   = vcnt;
  assign hd_oe    = !slave_r;
  assign vd_oe    = !slave_r;
  assign hd_out   = slave_r || (hcnt >= HW'(act.hdw));
  assign vd_out   = slave_r || (vcnt >= VW'(act.vdw));

endmodule

// File: rtl/hv_sync_timer_chk.sv
module hv_sync_timer_chk #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hd_out,
  input logic          hd_oe,
  input logic          vd_out,
  input logic          vd_oe,
  input logic [HW-1:0] hcount_g,
  input logic [VW-1:0] vcount,
  input logic          sync_hit,
  input logic          realign,
  input logic          field_start,
  input logic          pend,
  input logic          cfg_we,
  input logic          cfg_now,
  input logic [HW-1:0] a_line,
  input logic [PW-1:0] a_hdw
);

  logic [HW-1:0] hb;
  always_comb begin
    hb[HW-1] = hcount_g[HW-1];
    for (int i = HW - 2; i >= 0; i--) hb[i] = hb[i+1] ^ hcount_g[i];
  end

  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_oe |-> (hd_out && vd_out && !vd_oe));

  p_sync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (hb == '0 && vcount == '0));

  p_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    realign && !sync_hit |=> hb == '0);

  p_hd_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_oe && hb == '0 && a_hdw != '0) |-> !hd_out);

  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hb != '0 |-> hb == $past(hb) + HW'(1));

  p_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(field_start && pend) && !(cfg_we && cfg_now)) |=> $stable(a_line));

endmodule

bind hv_sync_timer hv_sync_timer_chk #(.HW(HW), .VW(VW), .PW(PW)) u_chk (.*);

// File: tb/hv_sync_timer_bench.sv
module hv_sync_timer_bench;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int PW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, cfg_now = 0, cfg_slave = 1, cfg_sync_pol = 0;
  logic [HW-1:0] cfg_line_g = '0, cfg_last_g = '0;
  logic [VW-1:0] cfg_lines = '0;
  logic [PW-1:0] cfg_hd_w = '0, cfg_vd_w = '0;
  logic sync_in = 1, hd_in = 1, vd_in = 1;
  logic hd_out, hd_oe, vd_out, vd_oe;
  logic [HW-1:0] hcount_g;
  logic [VW-1:0] vcount;

  always #2 clk = ~clk;

  hv_sync_timer u_hv_sync_timer (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 0, done = 0;

  function automatic int g2b(int g);
    int b = 0;
    for (int i = 11; i >= 0; i--) b |= ((((b >> (i + 1)) ^ (g >> i)) & 1) << i);
    return b;
  endfunction
  function automatic int b2g(int b);
    return (b ^ (b >> 1)) & 32'hFFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reference model, in pixel counts
  int m_h, m_v, m_len, m_lastlen, m_lines, m_hdw, m_vdw;
  int s_len, s_lastlen, s_lines, s_hdw, s_vdw;
  bit m_pend, m_slave, m_pol, m_sq, m_hq, m_vq, m_arm;
  bit [6:0] m_dly;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_len = 32; m_lastlen = 32; m_lines = 6; m_hdw = 4; m_vdw = 1;
      s_len = 32; s_lastlen = 32; s_lines = 6; s_hdw = 4; s_vdw = 1;
      m_pend = 0; m_slave = 1; m_pol = 0; m_sq = 0; m_hq = 0; m_vq = 0; m_arm = 0; m_dly = 0;
    end else begin
      bit lastl, dn, son, shit, hf, vf, rl, fs;
      int endp;
      lastl = (m_v + 1 >= m_lines);
      endp  = (lastl ? m_lastlen : m_len) - 1;
      dn    = (m_h >= endp) || (m_h == 4095);
      son   = (sync_in == m_pol);
      shit  = !m_slave && son && !m_sq;
      hf    = m_slave && m_hq && !hd_in;
      vf    = m_slave && m_vq && !vd_in;
      rl    = m_slave && m_dly[6];
      fs    = m_slave ? vf : (shit || (dn && lastl));
      if (shit) begin m_h = 0; m_v = 0; end
      else if (rl || dn) begin
        m_h = 0;
        m_v = ((rl && m_arm) || lastl) ? 0 : m_v + 1;
      end else m_h = m_h + 1;
      if (vf) m_arm = 1; else if (rl) m_arm = 0;
      m_dly = {m_dly[5:0], hf};
      m_hq = hd_in; m_vq = vd_in; m_sq = son;
      if (cfg_we && cfg_now) begin
        m_len = g2b(cfg_line_g) + 4; m_lastlen = g2b(cfg_last_g) + 4;
        m_lines = cfg_lines; m_hdw = cfg_hd_w; m_vdw = cfg_vd_w;
        s_len = m_len; s_lastlen = m_lastlen; s_lines = m_lines; s_hdw = m_hdw; s_vdw = m_vdw;
        m_pend = 0;
      end else begin
        if (fs && m_pend) begin
          m_len = s_len; m_lastlen = s_lastlen; m_lines = s_lines; m_hdw = s_hdw; m_vdw = s_vdw;
          m_pend = 0;
        end
        if (cfg_we) begin
          s_len = g2b(cfg_line_g) + 4; s_lastlen = g2b(cfg_last_g) + 4;
          s_lines = cfg_lines; s_hdw = cfg_hd_w; s_vdw = cfg_vd_w;
          m_pend = 1;
        end
      end
      if (cfg_we) begin m_slave = cfg_slave; m_pol = cfg_sync_pol; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(hcount_g == b2g(m_h), "R2 R3 R8 R9 R10 R11 R12 hcount", hcount_g, b2g(m_h));
      check(vcount == m_v, "R3 R7 R8 R9 R11 vcount", vcount, m_v);
      check(hd_out == (m_slave ? 1'b1 : (m_h >= m_hdw)), "R4 R6 hd_out", hd_out,
            m_slave ? 1 : int'(m_h >= m_hdw));
      check(vd_out == (m_slave ? 1'b1 : (m_v >= m_vdw)), "R4 R6 vd_out", vd_out,
            m_slave ? 1 : int'(m_v >= m_vdw));
      check(hd_oe == !m_slave && vd_oe == !m_slave, "R4 R6 R10 oe", hd_oe, !m_slave);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      check(0, "watchdog", cyc, 190000);
      report();
    end
  end

  function automatic int hb_now();
    return g2b(hcount_g);
  endfunction

  task automatic wr(bit now, bit slave, bit pol, int pix, int lastpix, int lines, int hdw, int vdw);
    @(negedge clk);
    cfg_we = 1; cfg_now = now; cfg_slave = slave; cfg_sync_pol = pol;
    cfg_line_g = HW'(b2g(pix - 4)); cfg_last_g = HW'(b2g(lastpix - 4));
    cfg_lines = VW'(lines); cfg_hd_w = PW'(hdw); cfg_vd_w = PW'(vdw);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic hd_period(output int n);
    n = 0;
    while (hd_out !== 1'b1) @(negedge clk);
    while (hd_out !== 1'b0) @(negedge clk);
    @(negedge clk); n = 1;
    while (hd_out !== 1'b1) begin @(negedge clk); n++; end
    while (hd_out !== 1'b0) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, v0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(hd_oe == 0 && vd_oe == 0, "R1 enables", hd_oe, 0);
    check(hd_out == 1 && vd_out == 1, "R1 sync outs", {hd_out, vd_out}, 3);
    check(hcount_g == 0 && vcount == 0, "R1 counters", hcount_g, 0);
    rst_n = 1;
    cmp_en = 1;
    repeat (5) @(negedge clk);
    check(hd_oe == 0, "R1 slave default", hd_oe, 0);

    // R2: 1560 pixels from Gray(1556)
    wr(1, 0, 0, 1560, 1560, 4, 4, 1);
    hd_period(n);
    check(n == 1560, "R2 line length", n, 1560);

    // R5: sync restart, held level does not repeat
    wr(1, 0, 0, 40, 40, 6, 4, 1);
    repeat (50) @(negedge clk);
    sync_in = 0;
    @(negedge clk);
    check(hcount_g == 0 && vcount == 0, "R5 sync restart", hb_now(), 0);
    repeat (5) @(negedge clk);
    check(hb_now() == 5, "R5 held level", hb_now(), 5);
    sync_in = 1;

    // R3: last line length and field size
    wr(1, 0, 0, 40, 24, 3, 4, 1);
    while (!(vcount == 0 && hcount_g == 0)) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!(vcount == 0 && hcount_g == 0));
    check(n == 40 + 40 + 24, "R3 field length", n, 104);

    // R10: immediate write
    wr(1, 0, 0, 24, 24, 6, 3, 1);
    hd_period(n);
    check(n == 24, "R10 immediate line", n, 24);

    // R9: deferred write keeps old length until field start
    wr(0, 0, 0, 60, 60, 6, 3, 1);
    while (vcount != 2) @(negedge clk);
    hd_period(n);
    check(n == 24, "R9 held before field start", n, 24);
    while (vcount != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    hd_period(n);
    check(n == 60, "R9 applied after field start", n, 60);

    // R11: deferred write on the field start edge
    wr(0, 0, 0, 48, 48, 6, 3, 1);
    while (vcount != 0) @(negedge clk);
    while (!(vcount == 5 && hb_now() == 47)) @(negedge clk);
    cfg_we = 1; cfg_now = 0; cfg_slave = 0; cfg_sync_pol = 0;
    cfg_line_g = HW'(b2g(36 - 4)); cfg_last_g = HW'(b2g(36 - 4)); cfg_lines = 6;
    @(negedge clk); cfg_we = 0;
    hd_period(n);
    check(n == 48, "R11 older set applied", n, 48);
    while (vcount != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    hd_period(n);
    check(n == 36, "R11 newer set pending", n, 36);

    // R12: shrink below current index
    wr(1, 0, 0, 60, 60, 6, 3, 1);
    while (hb_now() != 50) @(negedge clk);
    cfg_we = 1; cfg_now = 1; cfg_line_g = HW'(b2g(16)); cfg_last_g = HW'(b2g(16));
    @(negedge clk); cfg_we = 0;
    @(negedge clk);
    check(hb_now() == 0, "R12 early line end", hb_now(), 0);

    // R6: slave realignment latency
    wr(1, 1, 0, 1560, 1560, 6, 3, 1);
    hd_in = 1; vd_in = 1;
    repeat (20) @(negedge clk);
    hd_in = 0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    check(hb_now() != 0, "R6 not yet realigned", hb_now(), 1);
    @(negedge clk);
    check(hb_now() == 0, "R6 realigned after seven", hb_now(), 0);
    check(hd_out == 1 && vd_out == 1 && hd_oe == 0, "R6 slave quiet", hd_out, 1);
    hd_in = 1;

    // R8: realignment coinciding with line end
    wr(1, 1, 0, 40, 40, 6, 3, 1);
    while (!(hb_now() == 32 && vcount < 4)) @(negedge clk);
    v0 = vcount;
    hd_in = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(hb_now() == 0 && vcount == v0 + 1, "R8 single advance", vcount, v0 + 1);
    hd_in = 1;

    // R7: field restart via vd_in
    repeat (10) @(negedge clk);
    while (vcount == 0) @(negedge clk);
    vd_in = 0; hd_in = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(vcount == 0 && hb_now() == 0, "R7 field restart", vcount, 0);
    vd_in = 1; hd_in = 1;

    // random phase, checked by the model on every cycle
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      cfg_we = 0;
      if ($urandom % 100 < 2) begin
        cfg_we = 1;
        cfg_now = ($urandom % 3 == 0);
        if ($urandom % 10 == 0) cfg_slave = ~cfg_slave;
        if ($urandom % 10 == 0) cfg_sync_pol = ~cfg_sync_pol;
        cfg_line_g = HW'(b2g(4 + $urandom % 37));
        cfg_last_g = HW'(b2g(4 + $urandom % 37));
        cfg_lines = VW'(2 + $urandom % 5);
        cfg_hd_w = PW'($urandom % 7);
        cfg_vd_w = PW'($urandom % 4);
      end
      if ($urandom % 100 < 1) sync_in = ~sync_in;
      if ($urandom % 100 < 4) hd_in = ~hd_in;
      if ($urandom % 100 < 1) vd_in = ~vd_in;
    end
    @(negedge clk);
    cfg_we = 0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule